// File: doc/BRIEF.md
# SPI Flash Operation Sequencer

This block lets software run one complete SPI flash operation with a single register write. Software loads a flash address, puts any data to be written into a 64-byte staging buffer, and then writes the combined control/status word. That write sets the go bit and carries the operation code and the byte count. The sequencer then drives a single-chip-select SPI master on its own. It sends a write-enable frame where one is needed, then the command frame with its 24-bit address and any data bytes. After a program or erase it keeps polling the flash status register until the device is no longer busy.

Completion and failure are reported as sticky flags in the low byte of the combined register. Software clears these flags by writing ones to them, and it may do so in the same write that starts the next operation. Data read from the flash lands in the staging buffer, which software can read or write one byte, one halfword or one word at a time. Operations of 1 to 64 bytes are supported. There is one read type, one program type and two sector-erase sizes.

Top module: `spifl_ctrl`

## Requirements
- R1: Reset clears the done and error flags and the in-progress bit, so the combined register reads 0. Chip select is high and the SPI clock is low.
- R2: Register words are selected by byte offset: combined register at 0x04, address register at 0x08 (low 24 bits, upper bits read 0), buffer word n at 0x10+4n. Each byte enable writes one byte lane. Buffer byte k sits in word k/4, bits 8*(k%4)+7 down to 8*(k%4).
- R3: A write to 0x04 with bit 16 set and byte lane 2 enabled starts an operation when the cycle field (bits 20:17) holds a known code. Bit 5 reads 1 from the next clock edge until the operation ends.
- R4: Cycle code 0 (read) sends one frame: opcode 0x03, then the 24-bit address MSB first, then clocks in N bytes, where N is the count field (bits 29:24) plus one. Byte i of the read goes to buffer byte i. A read sends no write-enable frame and does no status polling.
- R5: Cycle code 2 (program) first sends a separate write-enable frame (0x06). It then sends a frame with opcode 0x02, the address and buffer bytes 0..N-1.
- R6: Cycle code 3 sends a write-enable frame and then opcode 0x20 with the address. Cycle code 4 does the same with opcode 0xD8. Neither sends data bytes.
- R7: After a program or erase, the block sends read-status frames (0x05 plus one response byte) until the response has bit 0 clear. Only after that does it report completion.
- R8: The done flag (bit 0) is set on the same edge on which the in-progress bit clears. If a clear and a set fall on the same edge, the set wins.
- R9: A go write that arrives while an operation is in progress is ignored and sets the error flag (bit 1).
- R10: A go write whose cycle code is not 0, 2, 3 or 4 sets the error flag, starts no frame and leaves chip select high.
- R11: Writing a 1 to bit 0 or bit 1 with lane 0 enabled clears that flag. This also works in the same write that sets go.
- R12: The SPI link runs in mode 0. SCK idles low whenever chip select is high, and MOSI changes only while SCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A register write takes effect at the clock edge on which it is presented. Read data is combinational on the offset, so the bench samples it one time step after the negative edge on which it sets the offset. The in-progress bit and the error flag of a rejected or ignored go are due one edge after the write, and the bench reads them on the very next read. Completion has no fixed latency because it depends on SCK division, frame gaps and the flash's busy time. The bench therefore polls the in-progress bit and checks the done flag in the same read in which in-progress is first seen clear. It then compares frame counts, opcodes, addresses and buffer bytes against its own flash model.

// File: rtl/spifl_pkg.sv
package spifl_pkg;

    localparam int FL_ADDR_W = 24;

    // word indices of the register map (byte offset >> 2)
    localparam int STAT_WIDX = 1;
    localparam int ADDR_WIDX = 2;
    localparam int BUF_WIDX0 = 4;

    // combined register bit positions
    localparam int B_DONE  = 0;
    localparam int B_ERR   = 1;
    localparam int B_BUSY  = 5;
    localparam int B_GO    = 16;
    localparam int CYC_LSB = 17;
    localparam int CYC_W   = 4;
    localparam int CNT_LSB = 24;
    localparam int CNT_W   = 6;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_RDSR = 8'h05;

    typedef enum logic [3:0] {
        CYC_RD   = 4'd0,
        CYC_PROG = 4'd2,
        CYC_SE4  = 4'd3,
        CYC_SE64 = 4'd4
    } cyc_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_LAUNCH, PH_WREN, PH_CMD, PH_DATA, PH_POLL, PH_GAP, PH_DONE
    } phase_e;

    typedef struct packed {
        cyc_e                 cyc;
        logic [FL_ADDR_W-1:0] addr;
        logic [CNT_W-1:0]     cnt;
    } op_t;

    function automatic logic cyc_known(input logic [CYC_W-1:0] c);
        return (c == 4'd0) || (c == 4'd2) || (c == 4'd3) || (c == 4'd4);
    endfunction

    function automatic logic [7:0] cyc_opcode(input cyc_e c);
        case (c)
            CYC_PROG: return 8'h02;
            CYC_SE4:  return 8'h20;
            CYC_SE64: return 8'hD8;
            default:  return 8'h03;
        endcase
    endfunction

    function automatic logic cyc_has_data(input cyc_e c);
        return (c == CYC_RD) || (c == CYC_PROG);
    endfunction

endpackage

// File: rtl/spifl_regs.sv
module spifl_regs
    import spifl_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [7:0]  addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        busy,
    input  logic        op_done,
    output logic        go_ok,
    output op_t         op,
    output logic        flag_done,
    output logic        flag_err,
    input  logic        sq_we,
    input  logic [$clog2(BUF_BYTES)-1:0] sq_idx,
    input  logic [7:0]  sq_wbyte,
    output logic [7:0]  sq_rbyte
);
    localparam int IDX_W     = $clog2(BUF_BYTES);
    localparam int BUF_WORDS = BUF_BYTES / 4;

    logic [7:0]           bytes_q [BUF_BYTES];
    logic [FL_ADDR_W-1:0] addr_q;
    logic [5:0]           widx;
    logic [5:0]           woff;
    logic [IDX_W-3:0]     wk;
    logic                 stat_wr, go_req, err_set;

    assign widx    = addr[7:2];
    assign woff    = widx - 6'(BUF_WIDX0);
    assign wk      = woff[IDX_W-3:0];
    assign stat_wr = wr && (widx == 6'(STAT_WIDX));
    assign go_req  = stat_wr && be[2] && wdata[B_GO];
    assign go_ok   = go_req && !busy && cyc_known(wdata[CYC_LSB +: CYC_W]);
    assign err_set = go_req && !go_ok;
    assign sq_rbyte = bytes_q[sq_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_BYTES; i++) bytes_q[i] <= '0;
        end else begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                if (wr && widx == 6'(BUF_WIDX0 + i / 4) && be[i % 4])
                    bytes_q[i] <= wdata[8 * (i % 4) +: 8];
            end
            if (sq_we) bytes_q[sq_idx] <= sq_wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            op        <= '{cyc: CYC_RD, addr: '0, cnt: '0};
            flag_done <= 1'b0;
            flag_err  <= 1'b0;
        end else begin
            if (wr && widx == 6'(ADDR_WIDX)) begin
                if (be[0]) addr_q[7:0]   <= wdata[7:0];
                if (be[1]) addr_q[15:8]  <= wdata[15:8];
                if (be[2]) addr_q[23:16] <= wdata[23:16];
            end
            if (go_ok) begin
                op.cyc  <= cyc_e'(wdata[CYC_LSB +: CYC_W]);
                op.cnt  <= wdata[CNT_LSB +: CNT_W];
                op.addr <= addr_q;
            end
            // clear first, set afterwards: a set on the same edge wins
            if (stat_wr && be[0] && wdata[B_DONE]) flag_done <= 1'b0;
            if (op_done)                           flag_done <= 1'b1;
            if (stat_wr && be[0] && wdata[B_ERR])  flag_err  <= 1'b0;
            if (err_set)                           flag_err  <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (widx == 6'(STAT_WIDX)) begin
            rdata[B_DONE]                = flag_done;
            rdata[B_ERR]                 = flag_err;
            rdata[B_BUSY]                = busy;
            rdata[CYC_LSB +: CYC_W]      = op.cyc;
            rdata[CNT_LSB +: CNT_W]      = op.cnt;
        end else if (widx == 6'(ADDR_WIDX)) begin
            rdata[FL_ADDR_W-1:0] = addr_q;
        end else if (widx >= 6'(BUF_WIDX0) && widx < 6'(BUF_WIDX0 + BUF_WORDS)) begin
            rdata = {bytes_q[{wk, 2'd3}], bytes_q[{wk, 2'd2}],
                     bytes_q[{wk, 2'd1}], bytes_q[{wk, 2'd0}]};
        end
    end

endmodule

// File: rtl/spifl_shift.sv
module spifl_shift #(
    parameter int SCK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = $clog2(SCK_DIV + 1);

    logic [CW-1:0] cnt;
    logic          run;
    logic [2:0]    bit_n;
    logic [7:0]    sh;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            run     <= 1'b0;
            bit_n   <= '0;
            sh      <= '0;
            rx_byte <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh    <= tx_byte;
                run   <= 1'b1;
                cnt   <= '0;
                bit_n <= '0;
                sck   <= 1'b0;
            end else if (run) begin
                if (cnt == CW'(SCK_DIV - 1)) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_n == 3'd7) begin
                            run  <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bit_n <= bit_n + 3'd1;
                            sh    <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/spifl_seq.sv
module spifl_seq
    import spifl_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int CS_GAP    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_ok,
    input  op_t        op,
    output logic       busy,
    output logic       op_done,
    output logic       cs_n,
    output logic       sh_start,
    output logic [7:0] sh_byte,
    input  logic       sh_done,
    input  logic [7:0] sh_rx,
    output logic       sq_we,
    output logic [$clog2(BUF_BYTES)-1:0] sq_idx,
    output logic [7:0] sq_wbyte,
    input  logic [7:0] sq_rbyte
);
    localparam int IDX_W = $clog2(BUF_BYTES);
    localparam int GW    = $clog2(CS_GAP + 1);

    phase_e        ph, ph_after;
    logic [6:0]    bidx;
    logic          wait_q;
    logic [GW-1:0] gcnt;
    logic          last_data;

    assign busy      = (ph != PH_IDLE);
    assign op_done   = (ph == PH_DONE);
    assign sh_start  = (ph == PH_WREN || ph == PH_CMD || ph == PH_DATA || ph == PH_POLL) && !wait_q;
    assign last_data = (bidx == {1'b0, op.cnt});
    assign sq_idx    = bidx[IDX_W-1:0];
    assign sq_we     = (ph == PH_DATA) && sh_done && (op.cyc == CYC_RD);
    assign sq_wbyte  = sh_rx;

    always_comb begin
        case (ph)
            PH_WREN: sh_byte = OPC_WREN;
            PH_CMD: begin
                case (bidx[1:0])
                    2'd0:    sh_byte = cyc_opcode(op.cyc);
                    2'd1:    sh_byte = op.addr[23:16];
                    2'd2:    sh_byte = op.addr[15:8];
                    default: sh_byte = op.addr[7:0];
                endcase
            end
            PH_DATA: sh_byte = (op.cyc == CYC_PROG) ? sq_rbyte : 8'h00;
            PH_POLL: sh_byte = (bidx == 7'd0) ? OPC_RDSR : 8'h00;
            default: sh_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            ph_after <= PH_IDLE;
            bidx     <= '0;
            wait_q   <= 1'b0;
            gcnt     <= '0;
            cs_n     <= 1'b1;
        end else begin
            if (sh_start) wait_q <= 1'b1;
            case (ph)
                PH_IDLE: if (go_ok) ph <= PH_LAUNCH;
                PH_LAUNCH: begin
                    cs_n <= 1'b0;
                    bidx <= '0;
                    ph   <= (op.cyc == CYC_RD) ? PH_CMD : PH_WREN;
                end
                PH_WREN: if (sh_done) begin
                    wait_q   <= 1'b0;
                    cs_n     <= 1'b1;
                    ph_after <= PH_CMD;
                    ph       <= PH_GAP;
                end
                PH_CMD: if (sh_done) begin
                    wait_q <= 1'b0;
                    if (bidx == 7'd3) begin
                        bidx <= '0;
                        if (cyc_has_data(op.cyc)) begin
                            ph <= PH_DATA;
                        end else begin
                            cs_n     <= 1'b1;
                            ph_after <= PH_POLL;
                            ph       <= PH_GAP;
                        end
                    end else begin
                        bidx <= bidx + 7'd1;
                    end
                end
                PH_DATA: if (sh_done) begin
                    wait_q <= 1'b0;
                    if (last_data) begin
                        bidx <= '0;
                        cs_n <= 1'b1;
                        if (op.cyc == CYC_RD) begin
                            ph <= PH_DONE;
                        end else begin
                            ph_after <= PH_POLL;
                            ph       <= PH_GAP;
                        end
                    end else begin
                        bidx <= bidx + 7'd1;
                    end
                end
                PH_POLL: if (sh_done) begin
                    wait_q <= 1'b0;
                    if (bidx == 7'd0) begin
                        bidx <= 7'd1;
                    end else begin
                        bidx     <= '0;
                        cs_n     <= 1'b1;
                        ph_after <= sh_rx[0] ? PH_POLL : PH_DONE;
                        ph       <= PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (gcnt == GW'(CS_GAP - 1)) begin
                        gcnt <= '0;
                        ph   <= ph_after;
                        if (ph_after != PH_DONE) cs_n <= 1'b0;
                    end else begin
                        gcnt <= gcnt + GW'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spifl_ctrl.sv
module spifl_ctrl
    import spifl_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int SCK_DIV   = 2,
    parameter int CS_GAP    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int IDX_W = $clog2(BUF_BYTES);

    logic             seq_busy, op_done, go_ok, flag_done, flag_err;
    op_t              op;
    logic             sq_we;
    logic [IDX_W-1:0] sq_idx;
    logic [7:0]       sq_wbyte, sq_rbyte;
    logic             sh_start, sh_done;
    logic [7:0]       sh_byte, sh_rx;

    spifl_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .be(reg_be),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(seq_busy), .op_done(op_done),
        .go_ok(go_ok), .op(op), .flag_done(flag_done), .flag_err(flag_err),
        .sq_we(sq_we), .sq_idx(sq_idx), .sq_wbyte(sq_wbyte), .sq_rbyte(sq_rbyte)
    );

    spifl_seq #(.BUF_BYTES(BUF_BYTES), .CS_GAP(CS_GAP)) u_seq (
        .clk(clk), .rst(rst), .go_ok(go_ok), .op(op), .busy(seq_busy),
        .op_done(op_done), .cs_n(spi_cs_n), .sh_start(sh_start), .sh_byte(sh_byte),
        .sh_done(sh_done), .sh_rx(sh_rx), .sq_we(sq_we), .sq_idx(sq_idx),
        .sq_wbyte(sq_wbyte), .sq_rbyte(sq_rbyte)
    );

    spifl_shift #(.SCK_DIV(SCK_DIV)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_byte), .done(sh_done),
        .rx_byte(sh_rx), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
    );

endmodule

// File: rtl/spifl_ctrl_chk.sv
module spifl_ctrl_chk
    import spifl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [3:0]  reg_be,
    input logic [31:0] reg_wdata,
    input logic        spi_cs_n,
    input logic        spi_sck,
    input logic        seq_busy,
    input logic        op_done,
    input logic        flag_done,
    input logic        flag_err
);
    logic stat_wr, go_req, known;

    assign stat_wr = reg_wr && (reg_addr[7:2] == 6'(STAT_WIDX));
    assign go_req  = stat_wr && reg_be[2] && reg_wdata[B_GO];
    assign known   = cyc_known(reg_wdata[CYC_LSB +: CYC_W]);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (spi_cs_n && !spi_sck && !flag_done && !flag_err && !seq_busy));

    p_go_starts_r3: assert property (@(posedge clk) disable iff (rst)
        (go_req && known && !seq_busy) |=> seq_busy);

    p_done_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_done) |-> ($past(op_done) && !seq_busy));

    p_done_set_r8: assert property (@(posedge clk) disable iff (rst)
        op_done |=> (flag_done && !seq_busy));

    p_busy_go_err_r9: assert property (@(posedge clk) disable iff (rst)
        (go_req && seq_busy) |=> flag_err);

    p_bad_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        (go_req && !known && !seq_busy) |=> (flag_err && !seq_busy && spi_cs_n));

    p_w1c_done_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && reg_be[0] && reg_wdata[B_DONE] && !op_done) |=> !flag_done);

    p_cs_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !seq_busy |-> spi_cs_n);

    p_sck_low_r12: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

endmodule

bind spifl_ctrl spifl_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .seq_busy(seq_busy), .op_done(op_done), .flag_done(flag_done), .flag_err(flag_err)
);

// File: tb/tb_spifl_ctrl.sv
module tb_spifl_ctrl;
    localparam int BUSY_N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    spifl_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #4 clk = ~clk;

    // ---------------- flash model ----------------
    logic [7:0]  fmem [256];
    logic [7:0]  exp_mem [256];
    logic [7:0]  f_in, f_op, f_tx;
    logic [23:0] f_addr, last_addr;
    int f_bits = 0, f_byte = 0, f_busy = 0, last_len = 0;
    bit f_wel = 0;
    int n_frames = 0, n_wren = 0, n_rdsr = 0, n_rd = 0, n_pp = 0;
    int n_se4 = 0, n_se64 = 0, n_wel_viol = 0, n_mode_viol = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task flash_byte(input logic [7:0] b);
        if (f_byte == 0) begin
            f_op = b;
            case (b)
                8'h06: begin f_wel = 1; n_wren++; end
                8'h05: begin n_rdsr++; f_tx = {7'd0, f_busy > 0}; end
                8'h03: n_rd++;
                8'h02: begin n_pp++;   if (!f_wel) n_wel_viol++; end
                8'h20: begin n_se4++;  if (!f_wel) n_wel_viol++; end
                8'hD8: begin n_se64++; if (!f_wel) n_wel_viol++; end
                default: ;
            endcase
        end else if (f_byte <= 3) begin
            f_addr = {f_addr[15:0], b};
            if (f_byte == 3) begin
                last_addr = f_addr;
                last_len = 0;
                if (f_op == 8'h03) f_tx = fmem[f_addr[7:0]];
            end
        end else begin
            last_len++;
            if (f_op == 8'h03) f_tx = fmem[8'(f_addr + 24'(f_byte - 3))];
            if (f_op == 8'h02) fmem[8'(f_addr + 24'(f_byte - 4))] = b;
        end
    endtask

    always @(negedge spi_cs_n) begin
        f_bits = 0; f_byte = 0; n_frames++;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        f_in = {f_in[6:0], spi_mosi};
        f_bits++;
        if (f_bits == 8) begin
            f_bits = 0;
            flash_byte(f_in);
            f_byte++;
        end
    end

    always @(negedge spi_sck) if (!spi_cs_n) begin
        spi_miso = f_tx[7];
        f_tx = {f_tx[6:0], 1'b0};
    end

    always @(posedge spi_cs_n) if (f_byte > 0) begin
        if (f_op == 8'h05 && f_busy > 0) f_busy--;
        if (f_op == 8'h02 || f_op == 8'h20 || f_op == 8'hD8) begin
            f_busy = BUSY_N;
            f_wel = 0;
        end
        if (f_op == 8'h20 || f_op == 8'hD8)
            for (int i = 0; i < 256; i++) fmem[i] = 8'hFF;
    end

    // R12: MOSI must not move while SCK is high inside a frame
    always @(spi_mosi) if (!spi_cs_n && spi_sck) n_mode_viol++;

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input int cyc, input int cnt, input bit go);
        return 32'h0000_00FF | (32'(cyc) << 17) | (32'(cnt - 1) << 24) | (32'(go) << 16);
    endfunction

    task automatic wait_idle(output logic [31:0] st);
        for (int k = 0; k < 20000; k++) begin
            rd(8'h04, st);
            if (!st[5]) break;
        end
    endtask

    task automatic start_op(input int cyc, input int addr, input int cnt);
        wr(8'h08, 32'(addr), 4'hF);
        wr(8'h04, ctl(cyc, cnt, 1'b1), 4'hF);
    endtask

    task automatic fill_buf(input int cnt, input bit rnd, input int seed_off);
        for (int w = 0; w < (cnt + 3) / 4; w++) begin
            logic [31:0] v;
            v = rnd ? $urandom : {pat(4*w+3+seed_off), pat(4*w+2+seed_off),
                                  pat(4*w+1+seed_off), pat(4*w+seed_off)};
            wr(8'(8'h10 + 4 * w), v, 4'hF);
            for (int l = 0; l < 4; l++) buf_shadow[4*w+l] = v[8*l +: 8];
        end
    endtask

    logic [7:0] buf_shadow [64];

    task automatic check_buf(input string req, input int addr, input int cnt);
        for (int w = 0; w < (cnt + 3) / 4; w++) begin
            logic [31:0] v;
            rd(8'(8'h10 + 4 * w), v);
            for (int l = 0; l < 4; l++)
                if (4 * w + l < cnt)
                    chk(req, 32'(v[8*l +: 8]), 32'(exp_mem[(addr + 4*w + l) & 255]));
        end
    endtask

    task automatic do_prog(input int addr, input int cnt, input bit rnd);
        logic [31:0] st;
        int wren0, rdsr0, fr0;
        fill_buf(cnt, rnd, addr);
        wren0 = n_wren; rdsr0 = n_rdsr; fr0 = n_frames;
        start_op(2, addr, cnt);
        wait_idle(st);
        chk("R8 done after program", 32'(st[1:0]), 32'd1);
        chk("R5 one write-enable frame", 32'(n_wren - wren0), 32'd1);
        chk("R7 status polls", 32'(n_rdsr - rdsr0), 32'(BUSY_N + 1));
        chk("R5 program frame count", 32'(n_frames - fr0), 32'(BUSY_N + 3));
        chk("R5 program address", 32'(last_addr), 32'(addr));
        chk("R5 program length", 32'(last_len), 32'(cnt));
        for (int i = 0; i < cnt; i++) exp_mem[(addr + i) & 255] = buf_shadow[i];
        wr(8'h04, 32'h3, 4'h1);
    endtask

    task automatic do_read(input int addr, input int cnt);
        logic [31:0] st;
        int fr0, wren0, rdsr0;
        fr0 = n_frames; wren0 = n_wren; rdsr0 = n_rdsr;
        start_op(0, addr, cnt);
        wait_idle(st);
        chk("R8 done after read", 32'(st[1:0]), 32'd1);
        chk("R4 single frame", 32'(n_frames - fr0), 32'd1);
        chk("R4 no write-enable or poll", 32'((n_wren - wren0) + (n_rdsr - rdsr0)), 32'd0);
        chk("R4 read address", 32'(last_addr), 32'(addr));
        check_buf("R4 read data", addr, cnt);
        wr(8'h04, 32'h3, 4'h1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R3: watchdog, actual still running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        logic [31:0] st, v;
        int fr0, rd0, pp0, e0, rdsr0;
        void'($urandom(32'd7715));
        for (int i = 0; i < 256; i++) begin
            fmem[i] = pat(i * 3 + 1);
            exp_mem[i] = pat(i * 3 + 1);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h04, st);
        chk("R1 status after reset", st, 32'h0);
        chk("R1 cs high, sck low", {30'd0, spi_cs_n, spi_sck}, 32'h2);

        // R2 register map and byte lanes
        wr(8'h24, 32'h1122_3344, 4'hF);
        wr(8'h24, 32'h00AA_0000, 4'b0100);
        rd(8'h24, v);
        chk("R2 byte-lane buffer write", v, 32'h11AA_3344);
        wr(8'h08, 32'hFF12_3456, 4'hF);
        rd(8'h08, v);
        chk("R2 address register", v, 32'h0012_3456);
        wr(8'h08, 32'h0000_0077, 4'b0001);
        rd(8'h08, v);
        chk("R2 address lane 0", v, 32'h0012_3477);

        // R3/R4 directed read, busy bit on next edge
        fr0 = n_frames;
        start_op(0, 16, 8);
        rd(8'h04, st);
        chk("R3 in-progress bit", 32'(st[5]), 32'd1);
        chk("R11 go cleared old flags", 32'(st[1:0]), 32'd0);
        chk("R3 cycle and count fields", {st[29:24], st[20:17]}, {6'd7, 4'd0});
        wait_idle(st);
        chk("R8 done with busy clear", 32'(st[1:0]), 32'd1);
        chk("R4 single frame", 32'(n_frames - fr0), 32'd1);
        check_buf("R4 read data", 16, 8);

        // R11 write-one-to-clear
        wr(8'h04, 32'h0000_0001, 4'h1);
        rd(8'h04, st);
        chk("R11 done cleared", 32'(st[0]), 32'd0);

        // R5/R7 program then read back
        do_prog(64, 16, 1'b0);
        do_read(64, 16);
        do_prog(250, 6, 1'b0);
        do_read(250, 6);
        do_read(0, 1);

        // R6 erase 4K
        e0 = n_se4; rdsr0 = n_rdsr; fr0 = n_frames;
        start_op(3, 32'h1000, 1);
        wait_idle(st);
        chk("R6 4K erase opcode", 32'(n_se4 - e0), 32'd1);
        chk("R6 erase frames, no data", 32'(n_frames - fr0), 32'(BUSY_N + 3));
        chk("R6 erase address", 32'(last_addr), 32'h1000);
        chk("R6 no data bytes", 32'(last_len), 32'd0);
        chk("R7 erase polls", 32'(n_rdsr - rdsr0), 32'(BUSY_N + 1));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        wr(8'h04, 32'h3, 4'h1);
        do_read(100, 12);

        // R6 erase 64K
        e0 = n_se64;
        start_op(4, 32'h20000, 1);
        wait_idle(st);
        chk("R6 64K erase opcode", 32'(n_se64 - e0), 32'd1);
        chk("R8 done after erase", 32'(st[1:0]), 32'd1);
        wr(8'h04, 32'h3, 4'h1);

        // R9 go while busy
        rd0 = n_rd; pp0 = n_pp;
        start_op(0, 0, 64);
        wr(8'h04, ctl(2, 4, 1'b1) & 32'hFFFF_FF00, 4'hF);
        rd(8'h04, st);
        chk("R9 error on busy go", 32'(st[1]), 32'd1);
        chk("R9 still busy", 32'(st[5]), 32'd1);
        wait_idle(st);
        chk("R9 second go ignored", 32'((n_rd - rd0) * 16 + (n_pp - pp0)), 32'd16);
        chk("R9 first op finished", 32'(st[0]), 32'd1);
        check_buf("R9 read data intact", 0, 64);
        wr(8'h04, 32'h3, 4'h1);

        // R10 unknown cycle code
        fr0 = n_frames;
        wr(8'h04, ctl(7, 1, 1'b1), 4'hF);
        rd(8'h04, st);
        chk("R10 error flag", 32'(st[1]), 32'd1);
        chk("R10 not busy", 32'(st[5]), 32'd0);
        repeat (20) @(negedge clk);
        chk("R10 no frame", 32'(n_frames - fr0), 32'd0);
        chk("R10 cs high", 32'(spi_cs_n), 32'd1);
        wr(8'h04, 32'h2, 4'h1);
        rd(8'h04, st);
        chk("R11 error cleared", 32'(st[1]), 32'd0);

        // random program/read mix
        for (int r = 0; r < 10; r++) begin
            int a, c;
            a = int'($urandom % 192);
            c = int'($urandom % 64) + 1;
            if ($urandom % 2 == 0) do_prog(a, c, 1'b1);
            do_read(a, c);
        end

        chk("R5 write enable before every program or erase", 32'(n_wel_viol), 32'd0);
        chk("R12 MOSI stable while SCK high", 32'(n_mode_viol), 32'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule